// File: doc/BRIEF.md
# Quadruple Time-Redundant Adder

This block adds two 16-bit operands and a carry-in. It tolerates a single faulty adder without giving a wrong answer. The datapath holds only one quarter of the adder width, and that quarter is built three times. Over four successive clock cycles it works through the operands one 4-bit slice at a time. Each cycle the three copies add the same slice. A bitwise majority vote picks the sum slice, and a separate majority vote picks the slice carry. The voted carry is kept in a one-bit register and becomes the carry-in of the next slice. The full result appears only once all four slices are done.

A user pulses `start` while the block is idle. The operands and the carry-in are captured in that cycle. `busy` covers the four working cycles and `done` marks completion. `mismatch` reports whether any copy ever disagreed with the majority during the operation. For test, each adder copy has an XOR mask on its outputs. This lets a bench corrupt one or more copies on purpose and watch the voter mask the fault.

Top module: `qtr_adder`

## Requirements
- R1: After an operation, `{carryOut, sum}` equals `opA + opB + carryIn` as a 17-bit value. The slices are processed from least significant (bits 3:0) to most significant (bits 15:12).
- R2: `opA`, `opB` and `carryIn` are captured when a start is accepted. Later changes to these inputs do not affect the result.
- R3: `busy` is high for exactly four cycles, starting with the cycle after an accepted start. `done` is high for exactly one cycle, the cycle right after the last `busy` cycle.
- R4: The carry out of each slice is voted, registered, and used as the carry-in of the next slice, so a carry can travel across all four slices.
- R5: `faultMask[k*5 +: 5]` is XORed onto the outputs of adder copy k (k = 0, 1, 2). Bits 3:0 of that field hit the sum slice and bit 4 hits the slice carry. Any corruption of a single copy leaves `sum` and `carryOut` correct.
- R6: `mismatch` goes high if any copy differed from the majority in any iteration. It stays high until the next accepted start, which clears it. With an all-zero mask it stays low.
- R7: A `start` that arrives while `busy` is high is ignored. It does not change the operands, the result or the timing of `done`.
- R8: After reset, `busy`, `done`, `mismatch` and `carryOut` are low and `sum` is zero.
- R9: When two copies are corrupted the same way, the voted result follows those two copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| faultMask | input | 15 | Test XOR masks, five bits per adder copy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sum | output | 16 | Voted 16-bit result |
| carryOut | output | 1 | Voted carry out of bit 15 |
| mismatch | output | 1 | A copy disagreed during the last operation |

## Verification
The bench adds 0xFFFF + 0x0000 with carry-in high. The carry must ride the registered carry through every slice, and a design that drops or misorders the carry register gives 0x0000 without the final carry-out. A start pulsed mid-operation, together with changed operands, must leave the result and the `done` timing alone; a design that re-arms or samples the live operands would show the new values or a late `done`. One copy is then corrupted on every output bit, which must leave the sum right and raise `mismatch`; a broken voter would pass the corruption through. Finally, two copies are corrupted identically, so the result must follow them; a voter that favours a fixed copy would miss this.

// File: rtl/qtr_pkg.sv
package qtr_pkg;
  typedef struct packed {
    logic load;   // accepted start: capture operands, seed carry
    logic step;   // one slice iteration this cycle
    logic last;   // current iteration is the final slice
  } ctrlStrobes_t;
endpackage

// File: rtl/qtr_voter.sv
module qtr_voter #(
  parameter int W = 4
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] major,
  output logic         disagree
);
  always_comb begin
    major    = (inA & inB) | (inA & inC) | (inB & inC);
    disagree = (inA != inB) || (inB != inC);
  end
endmodule

// File: rtl/qtr_slice_adder.sv
module qtr_slice_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic [W:0]   mask,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] raw;
  always_comb begin
    raw  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    s    = raw[W-1:0] ^ mask[W-1:0];
    cout = raw[W] ^ mask[W];
  end
endmodule

// File: rtl/qtr_control.sv
module qtr_control
  import qtr_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  localparam int IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] sliceIdx,
  output logic             busy,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLICES - 1);

  always_comb begin
    strobes.load = start && !busy;
    strobes.step = busy;
    strobes.last = busy && (sliceIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      sliceIdx <= '0;
    end else begin
      done <= strobes.last;
      if (strobes.load) begin
        busy     <= 1'b1;
        sliceIdx <= '0;
      end else if (strobes.last) begin
        busy     <= 1'b0;
        sliceIdx <= '0;
      end else if (busy) begin
        sliceIdx <= sliceIdx + 1'b1;
      end
    end
  end

  // R3: done follows the final iteration and lasts one cycle
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    strobes.last |=> (done && !busy));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R1: slices advance in increasing order
  a_r1_idx_advance: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobes.last) |=> (busy && sliceIdx == $past(sliceIdx) + 1'b1));
  // R7: a start while busy does not restart the sequence
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && sliceIdx != '0) |=> (sliceIdx != '0 || !busy));
endmodule

// File: rtl/qtr_datapath.sv
module qtr_datapath
  import qtr_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4,
  localparam int WIDTH  = SLICE_W * NUM_SLICES,
  localparam int IDX_W  = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int COPIES = 3,
  localparam int MASK_W = COPIES * (SLICE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [IDX_W-1:0]  sliceIdx,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  input  logic [MASK_W-1:0] faultMask,
  output logic [WIDTH-1:0]  sum,
  output logic              carryOut,
  output logic              mismatch
);
  logic [WIDTH-1:0]   opAReg, opBReg, resultReg;
  logic               carryReg, mismatchReg;
  logic [SLICE_W-1:0] sliceA, sliceB;
  logic [SLICE_W-1:0] copySum [COPIES];
  logic               copyCarry [COPIES];
  logic [SLICE_W-1:0] votedSum;
  logic               votedCarry, sumDis, carryDis, iterDis;

  // 4-bit wide 4:1 operand slice multiplexers
  always_comb begin
    sliceA = opAReg[sliceIdx*SLICE_W +: SLICE_W];
    sliceB = opBReg[sliceIdx*SLICE_W +: SLICE_W];
  end

  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    qtr_slice_adder #(.W(SLICE_W)) u_add (
      .a    (sliceA),
      .b    (sliceB),
      .cin  (carryReg),
      .mask (faultMask[k*(SLICE_W+1) +: (SLICE_W+1)]),
      .s    (copySum[k]),
      .cout (copyCarry[k])
    );
  end

  qtr_voter #(.W(SLICE_W)) u_sumVote (
    .inA(copySum[0]), .inB(copySum[1]), .inC(copySum[2]),
    .major(votedSum), .disagree(sumDis)
  );
  qtr_voter #(.W(1)) u_carryVote (
    .inA(copyCarry[0]), .inB(copyCarry[1]), .inC(copyCarry[2]),
    .major(votedCarry), .disagree(carryDis)
  );

  assign iterDis = sumDis || carryDis;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAReg      <= '0;
      opBReg      <= '0;
      resultReg   <= '0;
      carryReg    <= 1'b0;
      mismatchReg <= 1'b0;
    end else if (strobes.load) begin
      opAReg      <= opA;
      opBReg      <= opB;
      resultReg   <= '0;
      carryReg    <= carryIn;
      mismatchReg <= 1'b0;
    end else if (strobes.step) begin
      resultReg[sliceIdx*SLICE_W +: SLICE_W] <= votedSum;
      carryReg    <= votedCarry;
      mismatchReg <= mismatchReg || iterDis;
    end
  end

  assign sum      = resultReg;
  assign carryOut = carryReg;
  assign mismatch = mismatchReg;

  // R6: with no fault injected the copies never disagree
  a_r6_clean_agree: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && faultMask == '0) |-> !iterDis);
  // R6: the flag is sticky until a new operation begins
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (mismatchReg && !strobes.load) |=> mismatchReg);
  // R2: captured operands hold while the operation runs
  a_r2_operands_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> ($stable(opAReg) && $stable(opBReg)));
endmodule

// File: rtl/qtr_adder.sv
module qtr_adder
  import qtr_pkg::*;
#(
  parameter int SLICE_W    = 4,
  parameter int NUM_SLICES = 4,
  localparam int WIDTH  = SLICE_W * NUM_SLICES,
  localparam int IDX_W  = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int MASK_W = 3 * (SLICE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  input  logic [MASK_W-1:0] faultMask,
  output logic              busy,
  output logic              done,
  output logic [WIDTH-1:0]  sum,
  output logic              carryOut,
  output logic              mismatch
);
  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] sliceIdx;

  qtr_control #(.NUM_SLICES(NUM_SLICES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobes(strobes), .sliceIdx(sliceIdx), .busy(busy), .done(done)
  );

  qtr_datapath #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sliceIdx(sliceIdx),
    .opA(opA), .opB(opB), .carryIn(carryIn), .faultMask(faultMask),
    .sum(sum), .carryOut(carryOut), .mismatch(mismatch)
  );
endmodule

// File: tb/qtr_adder_bench.sv
`timescale 1ns/1ps
module qtr_adder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        carryIn = 1'b0;
  logic [14:0] faultMask = '0;
  logic        busy, done, carryOut, mismatch;
  logic [15:0] sum;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  qtr_adder u_qtr_adder (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .carryIn(carryIn), .faultMask(faultMask), .busy(busy), .done(done),
    .sum(sum), .carryOut(carryOut), .mismatch(mismatch)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start at a negedge; returns at the negedge after done should rise.
  // midA/midB/midStart are applied at the second busy cycle.
  task automatic runOp(logic [15:0] a, logic [15:0] b, logic cin,
                       logic [14:0] mask, logic midStart,
                       logic [15:0] midA, logic [15:0] midB, string req);
    logic [16:0] exp;
    exp = {1'b0, a} + {1'b0, b} + {16'd0, cin};
    faultMask = mask;
    opA = a; opB = b; carryIn = cin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R3 busy first cycle"}, {31'd0, busy}, 32'd1);
    @(negedge clk);
    if (midStart) begin
      opA = midA; opB = midB; carryIn = ~cin; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check({req, " R3 busy fourth cycle"}, {31'd0, busy}, 32'd1);
    check({req, " R3 no early done"}, {31'd0, done}, 32'd0);
    @(negedge clk);
    check({req, " R3 done pulse"}, {31'd0, done}, 32'd1);
    check({req, " R3 busy fallen"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic expectResult(logic [16:0] exp, logic expMis, string req);
    check({req, " sum"}, {16'd0, sum}, {16'd0, exp[15:0]});
    check({req, " carryOut"}, {31'd0, carryOut}, {31'd0, exp[16]});
    check({req, " R6 mismatch"}, {31'd0, mismatch}, {31'd0, expMis});
    @(negedge clk);
    check({req, " R3 done one cycle"}, {31'd0, done}, 32'd0);
    check({req, " R7 stays idle"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic testReset();
    check("R8 busy", {31'd0, busy}, 32'd0);
    check("R8 done", {31'd0, done}, 32'd0);
    check("R8 mismatch", {31'd0, mismatch}, 32'd0);
    check("R8 carryOut", {31'd0, carryOut}, 32'd0);
    check("R8 sum", {16'd0, sum}, 32'd0);
  endtask

  task automatic testPlain(logic [15:0] a, logic [15:0] b, logic cin);
    runOp(a, b, cin, '0, 1'b0, '0, '0, "R1");
    expectResult({1'b0, a} + {1'b0, b} + {16'd0, cin}, 1'b0, "R1");
  endtask

  task automatic testRipple();
    // R4: carry travels across all four slices
    runOp(16'hFFFF, 16'h0000, 1'b1, '0, 1'b0, '0, '0, "R4");
    expectResult(17'h10000, 1'b0, "R4");
  endtask

  task automatic testStartWhileBusy();
    // R2/R7: live inputs and a second start during busy are ignored
    runOp(16'h1234, 16'h0FED, 1'b0, '0, 1'b1, 16'hAAAA, 16'h5555, "R7");
    expectResult(17'h02221, 1'b0, "R2 R7");
  endtask

  task automatic testSingleFault();
    // R5: copy 1 fully corrupted (bits 9:5)
    runOp(16'h8F3C, 16'h70C4, 1'b1, 15'b00000_11111_00000, 1'b0, '0, '0, "R5");
    expectResult({1'b0, 16'h8F3C} + {1'b0, 16'h70C4} + 17'd1, 1'b1, "R5");
  endtask

  task automatic testMismatchClear();
    // R6: a clean operation after a faulty one clears the flag
    runOp(16'h0001, 16'h0002, 1'b0, '0, 1'b0, '0, '0, "R6");
    expectResult(17'h00003, 1'b0, "R6 clear");
  endtask

  task automatic testDoubleFault();
    // R9: copies 0 and 2 both flip sum bit 0 of every slice
    runOp(16'h1357, 16'h2468, 1'b0, 15'b00001_00000_00001, 1'b0, '0, '0, "R9");
    expectResult(({1'b0, 16'h1357} + {1'b0, 16'h2468}) ^ 17'h01111, 1'b0 | 1'b1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPlain(16'h1234, 16'h4321, 1'b0);
    testPlain(16'hFFFF, 16'hFFFF, 1'b1);
    testPlain(16'h0000, 16'h0000, 1'b0);
    testRipple();
    testStartWhileBusy();
    testSingleFault();
    testMismatchClear();
    testDoubleFault();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule